// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block steers four shared, level-sensitive PCI interrupt lines (named A to D here) onto sixteen legacy interrupt-controller request lines. Each shared line has its own byte-wide steering register that holds the number of the target request line. A value of sixteen or more switches that shared line off. Several shared lines may point at one request line. Such a request line is high while any of the shared lines routed to it is high.

Software programs the steering registers through a byte-laned register write port. The block keeps a registered record of which shared line is currently asserting which request line. The record has one bit per (request line, shared line) pair, at index line*4 + pirq. It is rebuilt on every clock from the current steering values and input levels, so a change of route clears the old contribution and applies the new one together. Two side functions are purely combinational. A route query reports whether a given shared line is enabled and where it goes. A slot swizzle maps a device's function number and interrupt pin onto one of the four shared lines.

Top module: `pirq_router`

## Requirements
- R1: After a synchronous active-low reset every steering register holds 0x80, all sixteen `pic_req` outputs are low, and the route query reports disabled.
- R2: A write with `cfg_we` high updates steering register k (k=0..3 for shared lines A..D) from byte lane j of `cfg_wdata` (bits 8j+7:8j) only when `cfg_be[j]` is set and the lane's byte address `{cfg_addr[7:2],2'b00}+j` equals 0x60+k. Lanes at other addresses or with a clear enable change nothing.
- R3: A shared line whose steering value is 16 or greater drives no request line, whatever its input level.
- R4: When an enabled shared line's input changes, the request line it is steered to follows on the first rising clock edge that samples the new level.
- R5: A request line is the OR of all enabled shared lines steered to it.
- R6: After a steering register changes, the previous target drops (unless another source holds it) and the new target takes the current input level, on the clock edge after the register update.
- R7: `swz_pirq` equals (`swz_intx` + `swz_devfn[7:3]` - 1) mod 4, with intx 0..3 meaning pins A..D.
- R8: The route query for `qry_pin` gives `qry_en`=1 and `qry_line` = the steering value when that value is below 16. Otherwise it gives `qry_en`=0 and `qry_line`=0.
- R9: With `cfg_we` low the steering registers keep their values whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pirq_lvl | input | 4 | Levels of shared interrupt lines A..D (bit 0 = A) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Byte address of the write; bits 1:0 ignored |
| cfg_be | input | 4 | Byte-lane enables |
| cfg_wdata | input | 32 | Write data, lane j in bits 8j+7:8j |
| pic_req | output | 16 | Level requests to the interrupt controller |
| qry_pin | input | 2 | Shared line to query (0=A..3=D) |
| qry_en | output | 1 | Queried shared line is enabled |
| qry_line | output | 4 | Queried target request line, 0 when disabled |
| swz_devfn | input | 8 | Device/function number for the swizzle |
| swz_intx | input | 2 | Device interrupt pin (0=INTA..3=INTD) |
| swz_pirq | output | 2 | Resulting shared line index |

## Verification
The clocked properties assume that `rst_n` is held low for at least one edge at start-up. They also assume that `pirq_lvl` and the write port are stable around each rising edge, because the record samples them there. The bench drives every input on the falling edge and holds reset through several edges, so each sampled value is settled. Since levels may change on any cycle, the properties relate the record to the previous cycle's inputs and steering values rather than to a protocol, and the stimulus changes levels and routes both alone and together.

// File: rtl/pirq_router_pkg.sv
// Shared constants and helpers for the interrupt line router.
// Assumes the number of shared lines is a power of two.
package pirq_router_pkg;
    localparam int DEF_N_PIRQ  = 4;
    localparam int DEF_N_LINE  = 16;
    localparam int DEF_BASE    = 'h60;
    localparam int REG_W       = 8;
    localparam logic [REG_W-1:0] ROUTE_RST = 8'h80;
endpackage

// File: rtl/pirq_route_regs.sv
// Steering registers, one byte per shared line, written through a
// byte-laned port. Assumes addresses are byte addresses whose low bits
// select the lane and that the register window lies inside the address space.
module pirq_route_regs
    import pirq_router_pkg::*;
#(
    parameter int N_PIRQ = DEF_N_PIRQ,
    parameter int BASE   = DEF_BASE,
    parameter int AW     = 8,
    parameter int LANES  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [AW-1:0]                addr,
    input  logic [LANES-1:0]             be,
    input  logic [REG_W*LANES-1:0]       wdata,
    output logic [N_PIRQ-1:0][REG_W-1:0] route_q
);
    localparam int LG = $clog2(LANES);

    logic [AW-1:0] word_addr;

    // Align the incoming address to the first lane of its word.
    always_comb word_addr = {addr[AW-1:LG], LG'(0)};

    // Capture enabled lanes that land on a steering register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N_PIRQ; k++) route_q[k] <= ROUTE_RST;
        end else if (we) begin
            for (int j = 0; j < LANES; j++) begin
                for (int k = 0; k < N_PIRQ; k++) begin
                    if (be[j] && (int'(word_addr) + j == BASE + k))
                        route_q[k] <= wdata[REG_W*j +: REG_W];
                end
            end
        end
    end

    // R9: without a write strobe the registers hold.
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(route_q));
endmodule

// File: rtl/pirq_level_map.sv
// Registered record of which shared line asserts which request line,
// indexed line*N_PIRQ + pirq, rebuilt every clock from the current
// steering values and input levels. Assumes inputs settle before the edge.
module pirq_level_map
    import pirq_router_pkg::*;
#(
    parameter int N_PIRQ = DEF_N_PIRQ,
    parameter int N_LINE = DEF_N_LINE,
    localparam int LW    = $clog2(N_LINE),
    localparam int VW    = N_PIRQ * N_LINE
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_PIRQ-1:0]            lvl,
    input  logic [N_PIRQ-1:0][REG_W-1:0] route_q,
    output logic [N_PIRQ-1:0]            route_en,
    output logic [N_PIRQ-1:0][LW-1:0]    route_line,
    output logic [VW-1:0]                vec
);
    // Decode each steering value into an enable and a target line.
    always_comb begin
        for (int p = 0; p < N_PIRQ; p++) begin
            route_en[p]   = int'(route_q[p]) < N_LINE;
            route_line[p] = route_q[p][LW-1:0];
        end
    end

    // Rebuild the whole record from the present routes and levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec <= '0;
        end else begin
            for (int l = 0; l < N_LINE; l++)
                for (int p = 0; p < N_PIRQ; p++)
                    vec[l*N_PIRQ + p] <= lvl[p] && route_en[p] &&
                                         (int'(route_line[p]) == l);
        end
    end

    for (genvar p = 0; p < N_PIRQ; p++) begin : g_chk
        localparam logic [VW-1:0] COL = {N_LINE{N_PIRQ'(1) << p}};
        // R3: a disabled shared line leaves no mark in the record.
        p_disabled_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !route_en[p] |=> ((vec & COL) == '0));
        // R4: an enabled, asserted line marks its target on the next edge.
        p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (route_en[p] && lvl[p]) |=> vec[int'($past(route_line[p]))*N_PIRQ + p]);
        // R6: a line marks at most one target.
        p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(vec & COL) <= 1);
    end
endmodule

// File: rtl/pirq_swizzle.sv
// Rotating slot swizzle: device pin plus slot number minus one, modulo the
// number of shared lines. Assumes N_PIRQ is a power of two.
module pirq_swizzle
    import pirq_router_pkg::*;
#(
    parameter int N_PIRQ = DEF_N_PIRQ,
    localparam int PW    = $clog2(N_PIRQ)
) (
    input  logic [7:0]    devfn,
    input  logic [PW-1:0] intx,
    output logic [PW-1:0] pirq
);
    // Modulo arithmetic falls out of the truncated width.
    always_comb pirq = intx + PW'(devfn[7:3]) - PW'(1);
endmodule

// File: rtl/pirq_router.sv
// Top of the shared interrupt line router: steering registers, the
// assertion record, per-line OR, a route query and the slot swizzle.
// Assumes synchronous active-low reset held for at least one edge.
module pirq_router
    import pirq_router_pkg::*;
#(
    parameter int N_PIRQ = DEF_N_PIRQ,
    parameter int N_LINE = DEF_N_LINE,
    parameter int BASE   = DEF_BASE,
    localparam int LW    = $clog2(N_LINE),
    localparam int PW    = $clog2(N_PIRQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PIRQ-1:0] pirq_lvl,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [N_LINE-1:0] pic_req,
    input  logic [PW-1:0]     qry_pin,
    output logic              qry_en,
    output logic [LW-1:0]     qry_line,
    input  logic [7:0]        swz_devfn,
    input  logic [PW-1:0]     swz_intx,
    output logic [PW-1:0]     swz_pirq
);
    logic [N_PIRQ-1:0][REG_W-1:0] route_q;
    logic [N_PIRQ-1:0]            route_en;
    logic [N_PIRQ-1:0][LW-1:0]    route_line;
    logic [N_PIRQ*N_LINE-1:0]     vec;

    pirq_route_regs #(.N_PIRQ(N_PIRQ), .BASE(BASE), .AW(8), .LANES(4)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .be(cfg_be), .wdata(cfg_wdata), .route_q(route_q));

    pirq_level_map #(.N_PIRQ(N_PIRQ), .N_LINE(N_LINE)) u_map (
        .clk(clk), .rst_n(rst_n), .lvl(pirq_lvl), .route_q(route_q),
        .route_en(route_en), .route_line(route_line), .vec(vec));

    pirq_swizzle #(.N_PIRQ(N_PIRQ)) u_swz (
        .devfn(swz_devfn), .intx(swz_intx), .pirq(swz_pirq));

    // OR the record bits that belong to each request line.
    for (genvar l = 0; l < N_LINE; l++) begin : g_or
        always_comb pic_req[l] = |vec[l*N_PIRQ +: N_PIRQ];
    end

    // Report enable and target of the queried shared line.
    always_comb begin
        qry_en   = route_en[qry_pin];
        qry_line = route_en[qry_pin] ? route_line[qry_pin] : '0;
    end

    // R5: a request line can only be high if some input was high a cycle ago.
    p_req_needs_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|pic_req) |-> $past(|pirq_lvl));
    // R1: reset leaves every request line low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (pic_req == '0));
endmodule

// File: tb/pirq_router_tb.sv
module pirq_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pirq_lvl = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] pic_req;
    logic [1:0]  qry_pin = '0;
    logic        qry_en;
    logic [3:0]  qry_line;
    logic [7:0]  swz_devfn = '0;
    logic [1:0]  swz_intx = '0;
    logic [1:0]  swz_pirq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pirq_router u_dut (.*);

    // stimulus table: {routes D..A as bytes, pirq levels}
    localparam logic [35:0] VEC [6] = '{
        {32'h80808080, 4'b1111},
        {32'h100A0505, 4'b0001},
        {32'h100A0505, 4'b0011},
        {32'h100A0505, 4'b1111},
        {32'h0F0E0D0C, 4'b1010},
        {32'hFF030303, 4'b0100}
    };

    function automatic logic [15:0] model(input logic [31:0] r, input logic [3:0] l);
        logic [15:0] m = '0;
        for (int p = 0; p < 4; p++)
            if (l[p] && r[8*p +: 8] < 8'd16) m[r[8*p +: 4]] = 1'b1;
        return m;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = '0; cfg_wdata = '0;
    endtask

    task automatic query(input string req, input logic [1:0] pin,
                         input logic en, input logic [3:0] line);
        qry_pin = pin; #1;
        chk(req, {27'b0, qry_en, qry_line}, {27'b0, en, line});
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        pirq_lvl = 4'hF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pic_req", 32'(pic_req), 0);
        for (int p = 0; p < 4; p++) query("R1 query", 2'(p), 1'b0, 4'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'(pic_req), 0);

        // R3 R4 R5: table walk
        foreach (VEC[i]) begin
            wr(8'h60, 4'hF, VEC[i][35:4]);
            pirq_lvl = VEC[i][3:0];
            @(negedge clk);
            chk("R3/R4/R5 table", 32'(pic_req), 32'(model(VEC[i][35:4], VEC[i][3:0])));
        end

        // R8: query on last table routes (A..C=3, D=0xFF)
        query("R8 enabled", 2'd0, 1'b1, 4'd3);
        query("R8 disabled", 2'd3, 1'b0, 4'd0);

        // R2: partial byte enable touches only lane 1 (B)
        wr(8'h61, 4'b0010, 32'h0909_0909);
        query("R2 lane B", 2'd1, 1'b1, 4'd9);
        query("R2 lane A kept", 2'd0, 1'b1, 4'd3);
        query("R2 lane C kept", 2'd2, 1'b1, 4'd3);
        // R2: write outside the window
        wr(8'h64, 4'hF, 32'h0101_0101);
        query("R2 outside A", 2'd0, 1'b1, 4'd3);
        query("R2 outside D", 2'd3, 1'b0, 4'd0);

        // R9: strobe low ignored
        @(negedge clk);
        cfg_addr = 8'h60; cfg_be = 4'hF; cfg_wdata = 32'h0707_0707;
        @(negedge clk);
        cfg_be = '0;
        query("R9 no strobe", 2'd0, 1'b1, 4'd3);

        // R6: reroute A from 2 to 7 while asserted
        pirq_lvl = 4'b0001;
        wr(8'h60, 4'hF, 32'h8080_8002);
        @(negedge clk);
        chk("R6 initial", 32'(pic_req), 32'h4);
        wr(8'h60, 4'b0001, 32'h0000_0007);
        chk("R6 one edge after write", 32'(pic_req), 32'h4);
        @(negedge clk);
        chk("R6 moved", 32'(pic_req), 32'h80);

        // R4: deassert timing
        pirq_lvl = 4'b0000;
        @(negedge clk);
        chk("R4 deassert", 32'(pic_req), 0);
        // R3: disable via value 16 exactly
        pirq_lvl = 4'b0001;
        wr(8'h60, 4'b0001, 32'h0000_0010);
        @(negedge clk);
        chk("R3 value 16", 32'(pic_req), 0);

        // R7: swizzle
        for (int s = 0; s < 32; s++) begin
            for (int x = 0; x < 4; x++) begin
                swz_devfn = 8'(s << 3) | 8'(s % 8);
                swz_intx = 2'(x);
                #1;
                chk("R7 swizzle", 32'(swz_pirq), 32'((x + s + 3) % 4));
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule